// File: doc/BRIEF.md
# Bus Master Address Tenure Controller

This block runs the address phase of a bus master on a processor bus whose address and data phases are split. A requester holds a transfer request (physical address, read/write flag, burst flag) until the arbiter's grant is seen while the address bus is free. On the next clock the block starts its address tenure. It drives the formed address, asserts the address output-enable and the address-bus-busy indication, and pulses the transfer-start strobe. The tenure stays open until the slave's address acknowledge is sampled.

Burst transfers never step the address. A burst read presents the double-word-aligned address of the critical word. A burst write presents the first double word of the cache line. A high-impedance enable input selects between two output modes. In one mode the address pins are permanently driven. In the other they are released one clock after the acknowledge and read as all zeros, so the address input and output lines can be ORed together into a shared bidirectional address bus.

Top module: `addr_tenure_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle: `xfer_start`, `addr_busy` and `addr_oe` are 0, and with `hiz_en` = 1, `addr_out` is 0 and `addr_tristate` is 1.
- R2: A grant is qualified when `bus_grant` = 1, `req_valid` = 1 and `addr_busy` = 0 at a clock edge. In the cycle after a qualified grant, `xfer_start`, `addr_busy` and `addr_oe` are all 1 and `addr_out` carries the formed address.
- R3: A grant is ignored, with no `xfer_start` and no change of the driven address, when `req_valid` is 0 or while `addr_busy` is 1.
- R4: `xfer_start` is high for exactly one cycle per tenure.
- R5: `addr_busy` stays 1 through the cycle in which `addr_ack` is sampled 1. It and `addr_oe` are 0 from the next cycle on. `addr_oe` equals `addr_busy` at all times.
- R6: For a burst read (`req_burst` = 1, `req_write` = 0), the driven address is the request address with bits [2:0] (LSB = bit 0) cleared.
- R7: For a burst write (`req_burst` = 1, `req_write` = 1), the driven address is the request address with bits [LINE_LSB-1:0] cleared; the default line is 32 bytes, so bits [4:0] are cleared.
- R8: For a single-beat transfer (`req_burst` = 0), the driven address equals the request address unchanged.
- R9: The driven address is captured at the qualified grant. It stays constant for the whole tenure regardless of later `req_addr` values.
- R10: With `hiz_en` = 1 and `addr_oe` = 0, every bit of `addr_drive_en` is 0, `addr_out` is 0 and `addr_tristate` is 1. The release therefore shows in the cycle after `addr_ack` is sampled.
- R11: With `hiz_en` = 0, every bit of `addr_drive_en` is 1 and `addr_tristate` is 0. After a tenure, `addr_out` keeps the last address while `addr_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Transfer request pending |
| req_addr | input | ADDR_W | Physical address of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 1 = cache-line burst |
| bus_grant | input | 1 | Address bus grant from the arbiter |
| addr_ack | input | 1 | Address acknowledge from the slave |
| hiz_en | input | 1 | 1 = release address pins when not valid |
| addr_out | output | ADDR_W | Address pins, zero while released |
| addr_drive_en | output | ADDR_W | Per-bit drive enable of the address pins |
| addr_oe | output | 1 | Valid address is being driven |
| xfer_start | output | 1 | One-cycle transfer-start strobe |
| addr_busy | output | 1 | Address bus busy for this master |
| addr_tristate | output | 1 | Address pins are in the released state |

## Verification
Every registered result of a qualified grant (strobe, busy, output-enable and the formed address) is due one clock edge after the grant is sampled. The bench drives inputs on the falling edge and samples one time unit after the next rising edge. The release after an acknowledge is likewise due one edge after `addr_ack` is sampled. The bench checks that busy is still high just before that edge and that busy, output-enable and the drive pins have changed just after it. The drive pins depend on `hiz_en` combinationally, so those checks are made in the same sample as the state they follow.

// File: rtl/atc_pkg.sv
// Shared types for the address tenure controller.
// Assumes: two-state tenure machine; the data phase is handled elsewhere.
package atc_pkg;
    typedef enum logic [0:0] {
        ATC_IDLE   = 1'b0,
        ATC_TENURE = 1'b1
    } atc_state_e;
endpackage

// File: rtl/atc_addr_form.sv
// Forms the address presented on the bus from a request.
// Burst reads are cut down to the critical double word, burst writes to the
// start of the cache line, single beats pass unchanged.
// Assumes DW_BYTES and LINE_BYTES are powers of two with LINE_BYTES >= DW_BYTES.
module atc_addr_form #(
    parameter int ADDR_W     = 32,
    parameter int DW_BYTES   = 8,
    parameter int LINE_BYTES = 32
) (
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              is_write,
    input  logic              is_burst,
    output logic [ADDR_W-1:0] addr_formed
);
    localparam int DW_LSB   = $clog2(DW_BYTES);
    localparam int LINE_LSB = $clog2(LINE_BYTES);
    localparam logic [ADDR_W-1:0] DW_MASK   = ~((ADDR_W'(1) << DW_LSB) - ADDR_W'(1));
    localparam logic [ADDR_W-1:0] LINE_MASK = ~((ADDR_W'(1) << LINE_LSB) - ADDR_W'(1));

    // Purpose: choose the alignment that matches the transfer kind.
    always_comb begin
        if (!is_burst)
            addr_formed = addr_in;
        else if (is_write)
            addr_formed = addr_in & LINE_MASK;
        else
            addr_formed = addr_in & DW_MASK;
    end
endmodule

// File: rtl/atc_seq.sv
// Tenure sequencer: qualifies grants, pulses the start strobe and holds the
// tenure open until the address acknowledge is sampled.
// Assumes the requester holds req_valid until it sees xfer_start.
module atc_seq
    import atc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic bus_grant,
    input  logic addr_ack,
    output logic load,
    output logic in_tenure,
    output logic start
);
    atc_state_e state_q;
    logic       start_q;

    assign load      = req_valid && bus_grant && (state_q == ATC_IDLE);
    assign in_tenure = (state_q == ATC_TENURE);
    assign start     = start_q;

    // Purpose: advance the tenure state and generate the one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ATC_IDLE;
            start_q <= 1'b0;
        end else begin
            start_q <= load;
            case (state_q)
                ATC_IDLE:   if (load) state_q <= ATC_TENURE;
                ATC_TENURE: if (addr_ack) state_q <= ATC_IDLE;
                default:    state_q <= ATC_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/atc_drive.sv
// Address pin driver: captures the formed address and applies the selected
// output mode. In release mode the pins read zero when not driven so that
// they can be ORed with other drivers.
// Assumes oe is high exactly while a tenure is open.
module atc_drive #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              oe,
    input  logic              hiz_en,
    output logic [ADDR_W-1:0] pin_addr,
    output logic [ADDR_W-1:0] pin_drive_en,
    output logic              released
);
    logic [ADDR_W-1:0] addr_q;
    logic              driving;

    // Purpose: hold the address of the current or most recent tenure.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (load)
            addr_q <= addr_in;
    end

    assign driving  = oe || !hiz_en;
    assign released = !driving;

    for (genvar b = 0; b < ADDR_W; b++) begin : g_pin
        assign pin_drive_en[b] = driving;
        assign pin_addr[b]     = addr_q[b] & driving;
    end
endmodule

// File: rtl/addr_tenure_ctrl.sv
// Top of the bus master address tenure controller.
// Assumes a single outstanding address tenure and a synchronous active-low reset.
module addr_tenure_ctrl #(
    parameter int ADDR_W     = 32,
    parameter int DW_BYTES   = 8,
    parameter int LINE_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_burst,
    input  logic              bus_grant,
    input  logic              addr_ack,
    input  logic              hiz_en,
    output logic [ADDR_W-1:0] addr_out,
    output logic [ADDR_W-1:0] addr_drive_en,
    output logic              addr_oe,
    output logic              xfer_start,
    output logic              addr_busy,
    output logic              addr_tristate
);
    logic [ADDR_W-1:0] formed;
    logic              load;
    logic              in_tenure;

    atc_addr_form #(
        .ADDR_W(ADDR_W), .DW_BYTES(DW_BYTES), .LINE_BYTES(LINE_BYTES)
    ) u_form (
        .addr_in(req_addr), .is_write(req_write), .is_burst(req_burst),
        .addr_formed(formed)
    );

    atc_seq u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .bus_grant(bus_grant),
        .addr_ack(addr_ack), .load(load), .in_tenure(in_tenure), .start(xfer_start)
    );

    atc_drive #(.ADDR_W(ADDR_W)) u_drive (
        .clk(clk), .rst_n(rst_n), .load(load), .addr_in(formed), .oe(in_tenure),
        .hiz_en(hiz_en), .pin_addr(addr_out), .pin_drive_en(addr_drive_en),
        .released(addr_tristate)
    );

    assign addr_oe   = in_tenure;
    assign addr_busy = in_tenure;
endmodule

// File: rtl/atc_checker.sv
// Protocol checker for addr_tenure_ctrl, attached by bind.
// Assumes it observes only the top-level ports.
module atc_checker #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic              req_burst,
    input logic              bus_grant,
    input logic              addr_ack,
    input logic              hiz_en,
    input logic [ADDR_W-1:0] addr_out,
    input logic [ADDR_W-1:0] addr_drive_en,
    input logic              addr_oe,
    input logic              xfer_start,
    input logic              addr_busy,
    input logic              addr_tristate
);
    localparam int LINE_LSB = $clog2(LINE_BYTES);

    AST_GRANT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_grant && req_valid && !addr_busy) |=> (xfer_start && addr_busy && addr_oe)); // R2
    AST_NO_START_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_busy && !addr_ack) |=> !xfer_start); // R3
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start); // R4
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_busy && !addr_ack) |=> addr_busy); // R5
    AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_busy && addr_ack) |=> (!addr_busy && !addr_oe)); // R5
    AST_OE_MATCHES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        addr_oe == addr_busy); // R5
    AST_BURST_READ_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start && $past(req_burst) && !$past(req_write)) |-> (addr_out[2:0] == 3'b000)); // R6
    AST_BURST_WRITE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start && $past(req_burst) && $past(req_write)) |-> (addr_out[LINE_LSB-1:0] == '0)); // R7
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_busy && !xfer_start) |-> $stable(addr_out)); // R9
    AST_HIZ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (hiz_en && !addr_oe) |-> (addr_tristate && addr_out == '0 && addr_drive_en == '0)); // R10
    AST_ALWAYS_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !hiz_en |-> (!addr_tristate && addr_drive_en == '1)); // R11
endmodule

bind addr_tenure_ctrl atc_checker #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)
) u_atc_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_burst(req_burst), .bus_grant(bus_grant), .addr_ack(addr_ack),
    .hiz_en(hiz_en), .addr_out(addr_out), .addr_drive_en(addr_drive_en),
    .addr_oe(addr_oe), .xfer_start(xfer_start), .addr_busy(addr_busy),
    .addr_tristate(addr_tristate)
);

// File: tb/tb_addr_tenure_ctrl.sv
// Self-checking bench: directed corner cases plus seeded random tenures.
module tb_addr_tenure_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid, req_write, req_burst, bus_grant, addr_ack, hiz_en;
    logic [AW-1:0] req_addr;
    logic [AW-1:0] addr_out, addr_drive_en;
    logic          addr_oe, xfer_start, addr_busy, addr_tristate;

    int checks = 0;
    int failures = 0;

    addr_tenure_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_burst(req_burst), .bus_grant(bus_grant),
        .addr_ack(addr_ack), .hiz_en(hiz_en), .addr_out(addr_out),
        .addr_drive_en(addr_drive_en), .addr_oe(addr_oe), .xfer_start(xfer_start),
        .addr_busy(addr_busy), .addr_tristate(addr_tristate)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] a, logic w, logic b);
        if (!b) return a;
        if (w)  return a & ~32'h1F;
        return a & ~32'h7;
    endfunction

    task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One tenure: grant, optional busy-time grants, ack, release checks.
    task automatic tenure(logic [AW-1:0] a, logic w, logic b, logic hz, int dly, logic bg);
        logic [AW-1:0] e;
        string tag;
        e = exp_addr(a, w, b);
        tag = !b ? "R8" : (w ? "R7" : "R6");
        @(negedge clk);
        req_valid = 1; req_addr = a; req_write = w; req_burst = b;
        bus_grant = 1; hiz_en = hz; addr_ack = 0;
        @(posedge clk); #1;
        chk("R2 start", AW'(xfer_start), 1);
        chk("R2 busy", AW'(addr_busy), 1);
        chk("R2 oe", AW'(addr_oe), 1);
        chk(tag, addr_out, e);
        for (int k = 0; k < dly; k++) begin
            @(negedge clk);
            req_valid = bg; bus_grant = bg; req_addr = $urandom;
            @(posedge clk); #1;
            chk(bg ? "R3 grant while busy" : "R4 single strobe", AW'(xfer_start), 0);
            chk("R9 stable", addr_out, e);
            chk("R5 busy held", AW'(addr_busy), 1);
        end
        @(negedge clk);
        req_valid = 0; bus_grant = 0; addr_ack = 1; req_addr = $urandom;
        #1 chk("R5 busy in ack cycle", AW'(addr_busy), 1);
        @(posedge clk); #1;
        chk("R5 busy drops", AW'(addr_busy), 0);
        chk("R5 oe drops", AW'(addr_oe), 0);
        if (hz) begin
            chk("R10 addr zero", addr_out, 0);
            chk("R10 drive off", addr_drive_en, 0);
            chk("R10 tristate", AW'(addr_tristate), 1);
        end else begin
            chk("R11 addr held", addr_out, e);
            chk("R11 drive on", addr_drive_en, '1);
            chk("R11 no tristate", AW'(addr_tristate), 0);
        end
        @(negedge clk);
        addr_ack = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 0; req_valid = 0; req_addr = 0; req_write = 0; req_burst = 0;
        bus_grant = 0; addr_ack = 0; hiz_en = 1;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 start", AW'(xfer_start), 0);
        chk("R1 busy", AW'(addr_busy), 0);
        chk("R1 oe", AW'(addr_oe), 0);
        chk("R1 addr", addr_out, 0);
        chk("R1 tristate", AW'(addr_tristate), 1);
        @(negedge clk); rst_n = 1;

        // R3: grant without request is ignored
        @(negedge clk); bus_grant = 1; req_addr = 32'hDEAD_BEEF;
        @(posedge clk); #1;
        chk("R3 no req start", AW'(xfer_start), 0);
        chk("R3 no req busy", AW'(addr_busy), 0);
        chk("R3 no req addr", addr_out, 0);
        @(negedge clk); bus_grant = 0;

        tenure(32'h1234_567F, 0, 1, 1, 2, 0);  // R6 burst read
        tenure(32'h8000_00FF, 1, 1, 0, 1, 0);  // R7 burst write, R11 hold
        tenure(32'hABCD_EF13, 0, 0, 1, 0, 0);  // R8 single, ack at once
        tenure(32'h0000_0007, 1, 0, 1, 3, 1);  // R3 grant while busy

        // R11: idle with hiz off keeps last address
        @(negedge clk); hiz_en = 0;
        #1 chk("R11 idle hold", addr_out, 32'h0000_0007);
        chk("R11 idle drive", addr_drive_en, '1);

        for (int n = 0; n < 60; n++) begin
            int d;
            d = int'($urandom % 4);
            tenure($urandom, 1'($urandom), 1'($urandom), 1'($urandom), d,
                   (d > 0) && ($urandom % 3 == 0));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule